// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block gathers up to 31 peripheral interrupt lines and delivers them to a small number of processor contexts. Each source has a programmable priority. Each context has its own enable mask and its own threshold. A context's interrupt line rises when at least one source meets all of these conditions: it is waiting, it is enabled for that context, and its priority is strictly above that context's threshold. Software reads the context's claim register to learn which source won and to take ownership of it. It writes the same ID back to the claim register when its handler has finished.

Every source passes through a small gateway state machine before it reaches the arbiters. The gateway has three states: GW_IDLE, GW_PEND and GW_BUSY. GW_IDLE moves to GW_PEND when a request is seen. In level mode a request is a high input. In edge mode it is a 0-to-1 transition. GW_PEND moves to GW_BUSY when some context claims the source. GW_BUSY moves back to GW_IDLE on a valid completion. While the gateway is in GW_BUSY, further requests from the source are dropped. A parameter bit chooses level or edge mode for each source. The register interface is a plain 32-bit read/write bus. Read data is registered.

Top module: `irq_router`

## Requirements
- R1: The priority of source N is at byte address 4*N. It holds PRIO_W (3) bits and reads back zero-extended. Address 0 (source 0) always reads 0, and writes to it are ignored.
- R2: The enable mask of context k is the 32-bit word at 0x2000 + 0x80*k. Bit N enables source N. Bit 0 always reads 0.
- R3: The threshold of context k is at 0x200000 + 0x1000*k and holds PRIO_W bits. The claim/complete register of context k is at 0x200000 + 0x1000*k + 4.
- R4: ctx_irq[k] is 1 exactly when some source in GW_PEND is enabled for k and has a priority strictly greater than threshold k. The output is registered, so it follows the state one clock later. A threshold of 7 masks every source, and a priority of 0 never interrupts.
- R5: A claim read returns the ID of the eligible source with the highest priority, using the R4 eligibility rule. On a tie the lowest ID wins. When no source is eligible the read returns 0.
- R6: A claim moves the winning source to GW_BUSY on the same clock edge that captures the read data. A later claim from any context therefore does not return that source again.
- R7: A source in GW_BUSY accepts no new request until it is completed. After completion, a level source that is still high becomes pending again.
- R8: A completion write is ignored when the ID is 0, when the ID is above NSRC, or when the source is not enabled in the writing context's mask.
- R9: An edge-mode source becomes pending once per rising edge. Edges that arrive while it is pending or busy are dropped. An input held high after completion does not make the source pending again.
- R10: bus_rdata changes only on a read and is valid the clock after the read is presented. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NSRC | Source request lines; bit N is source N (1..NSRC) |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ctx_irq | output | NCTX | Interrupt line of each context |

## Verification
A request level needs one edge to reach GW_PEND and one more edge to appear on ctx_irq. The bench therefore waits two clocks after changing irq_src before it samples ctx_irq. Claim data is captured on the edge where the read is presented, and the bench samples it at the following falling edge. A completion frees the gateway on its write edge, and a level source that is still high becomes pending on the next edge. For this reason every claim that follows a completion is issued at least one idle cycle later. Random priority, enable, threshold and level patterns are compared with a bench model of the arbitration, and directed sequences cover ties, thresholds, ignored completions and edge drops.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic claim,
    input  logic complete,
    output logic pending
);
    gw_state_e state_q, state_d;
    logic      irq_prev;
    logic      req;

    assign req = EDGE ? (irq_in & ~irq_prev) : irq_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= GW_IDLE;
            irq_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            irq_prev <= irq_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (req)      state_d = GW_PEND;
            GW_PEND: if (claim)    state_d = GW_BUSY;
            GW_BUSY: if (complete) state_d = GW_IDLE;
            default:               state_d = GW_IDLE;
        endcase
    end

    always_comb pending = (state_q == GW_PEND);

    AST_CLAIM_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> pending); // R6
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_BUSY && !complete) |=> !pending); // R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             pend,
    input  logic [NSRC:1]             en,
    input  logic [NSRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic [ID_W-1:0]           win_id,
    output logic                      win_valid
);
    logic [PRIO_W-1:0] best;

    // Scanning upward with a strict compare keeps the lowest ID on ties;
    // starting from the threshold makes "above threshold" implicit.
    always_comb begin
        best   = thr;
        win_id = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > best)) begin
                best   = prio[i];
                win_id = ID_W'(i);
            end
        end
        win_valid = (win_id != '0);
    end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int          NSRC     = 31,
    parameter int          NCTX     = 2,
    parameter int          PRIO_W   = 3,
    parameter int          ADDR_W   = 24,
    parameter logic [31:0] EDGE_SEL = 32'h0000_01E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:1]     irq_src,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   ctx_irq
);
    localparam int          ID_W     = $clog2(NSRC + 1);
    localparam int          PRIO_MAX = (1 << PRIO_W) - 1;
    localparam logic [31:0] ENB_BASE = 32'h0000_2000;
    localparam logic [31:0] ENB_STEP = 32'h0000_0080;
    localparam logic [31:0] CTL_BASE = 32'h0020_0000;
    localparam logic [31:0] CTL_STEP = 32'h0000_1000;

    logic [NSRC:1][PRIO_W-1:0]  prio_q;
    logic [NCTX-1:0][NSRC:1]    en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic [31:0]                rdata_q, rd_d;
    logic [NCTX-1:0]            irq_q;

    logic [31:0]                addr_w;
    logic                       prio_hit;
    logic [9:0]                 prio_idx;
    logic [NCTX-1:0]            en_hit, thr_hit, clm_hit;
    logic [NSRC:1]              pend_v, claim_v, cmpl_v;
    logic [NCTX-1:0][ID_W-1:0]  win_id;
    logic [NCTX-1:0]            win_valid;

    assign addr_w   = 32'(bus_addr);
    assign prio_hit = bus_sel && (addr_w[31:12] == 20'd0);
    assign prio_idx = addr_w[11:2];

    for (genvar n = 1; n <= NSRC; n++) begin : g_src
        irq_gateway #(.EDGE(EDGE_SEL[n])) u_gw (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_src[n]),
            .claim    (claim_v[n]),
            .complete (cmpl_v[n]),
            .pending  (pend_v[n])
        );
    end

    for (genvar k = 0; k < NCTX; k++) begin : g_ctx
        localparam logic [31:0] ENB_A = ENB_BASE + 32'(k) * ENB_STEP;
        localparam logic [31:0] THR_A = CTL_BASE + 32'(k) * CTL_STEP;

        assign en_hit[k]  = bus_sel && (addr_w == ENB_A);
        assign thr_hit[k] = bus_sel && (addr_w == THR_A);
        assign clm_hit[k] = bus_sel && (addr_w == THR_A + 32'd4);

        irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .pend      (pend_v),
            .en        (en_q[k]),
            .prio      (prio_q),
            .thr       (thr_q[k]),
            .win_id    (win_id[k]),
            .win_valid (win_valid[k])
        );

        AST_MASK_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_q[k] == PRIO_W'(PRIO_MAX)) |=> !ctx_irq[k]); // R4
        AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
            (clm_hit[k] && !bus_wr && !win_valid[k]) |=> (bus_rdata == 32'd0)); // R5
        AST_CLAIM_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
            (clm_hit[k] && !bus_wr && win_valid[k]) |=> (bus_rdata == 32'($past(win_id[k])))); // R5
    end

    // Claim and completion strobes towards the gateways.
    always_comb begin
        claim_v = '0;
        cmpl_v  = '0;
        for (int k = 0; k < NCTX; k++) begin
            for (int i = 1; i <= NSRC; i++) begin
                if (clm_hit[k] && !bus_wr && win_valid[k] && (win_id[k] == ID_W'(i)))
                    claim_v[i] = 1'b1;
                if (clm_hit[k] && bus_wr && (bus_wdata == 32'(i)) && en_q[k][i])
                    cmpl_v[i] = 1'b1;
            end
        end
    end

    // Read data selection.
    always_comb begin
        rd_d = 32'd0;
        for (int i = 1; i <= NSRC; i++)
            if (prio_hit && (prio_idx == 10'(i))) rd_d = 32'(prio_q[i]);
        for (int k = 0; k < NCTX; k++) begin
            if (en_hit[k])  rd_d = 32'({en_q[k], 1'b0});
            if (thr_hit[k]) rd_d = 32'(thr_q[k]);
            if (clm_hit[k]) rd_d = 32'(win_id[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q  <= '0;
            en_q    <= '0;
            thr_q   <= '0;
            rdata_q <= '0;
            irq_q   <= '0;
        end else begin
            if (bus_sel && bus_wr) begin
                for (int i = 1; i <= NSRC; i++)
                    if (prio_hit && (prio_idx == 10'(i))) prio_q[i] <= bus_wdata[PRIO_W-1:0];
                for (int k = 0; k < NCTX; k++) begin
                    if (en_hit[k])  en_q[k]  <= bus_wdata[NSRC:1];
                    if (thr_hit[k]) thr_q[k] <= bus_wdata[PRIO_W-1:0];
                end
            end
            if (bus_sel && !bus_wr) rdata_q <= rd_d;
            irq_q <= win_valid;
        end
    end

    assign bus_rdata = rdata_q;
    assign ctx_irq   = irq_q;

    AST_ID0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && addr_w == 32'd0) |=> (bus_rdata == 32'd0)); // R1
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
    localparam int          NSRC     = 31;
    localparam int          NCTX     = 2;
    localparam int          PRIO_W   = 3;
    localparam int          ADDR_W   = 24;
    localparam logic [31:0] EDGE_SEL = 32'h0000_01E0;
    localparam logic [31:0] LVL_MASK = ~EDGE_SEL & 32'hFFFF_FFFE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC:1]     irq_src = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCTX-1:0]   ctx_irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rv;

    int          prio_m [32];
    logic [31:0] en_m   [NCTX];
    int          thr_m  [NCTX];

    irq_router #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
                 .EDGE_SEL(EDGE_SEL)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] a_prio(int n); return 32'(4 * n); endfunction
    function automatic logic [31:0] a_en(int k);   return 32'h2000 + 32'(k) * 32'h80; endfunction
    function automatic logic [31:0] a_thr(int k);  return 32'h20_0000 + 32'(k) * 32'h1000; endfunction
    function automatic logic [31:0] a_clm(int k);  return a_thr(k) + 32'd4; endfunction

    function automatic int exp_win(int k, logic [31:0] pend);
        int best = thr_m[k];
        int id = 0;
        for (int i = 1; i <= NSRC; i++)
            if (pend[i] && en_m[k][i] && prio_m[i] > best) begin
                best = prio_m[i];
                id = i;
            end
        return id;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_src = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // Reset state
        chk("R4 reset ctx_irq", 32'(ctx_irq), 0);
        rd(a_prio(1), rv); chk("R1 reset prio", rv, 0);
        rd(a_clm(0), rv);  chk("R5 reset claim", rv, 0);

        // Register map
        wr(a_prio(0), 7); rd(a_prio(0), rv); chk("R1 id0 prio", rv, 0);
        wr(a_prio(3), 5); rd(a_prio(3), rv); chk("R1 prio readback", rv, 5);
        wr(a_prio(3), 32'hFF); rd(a_prio(3), rv); chk("R1 prio width", rv, 7);
        rd(32'h1000, rv); chk("R10 unmapped", rv, 0);
        rd(32'h2004, rv); chk("R10 unmapped enable word", rv, 0);
        wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), rv); chk("R2 enable bit0", rv, 32'hFFFF_FFFE);
        wr(a_en(1), 0);
        wr(a_thr(1), 5); rd(a_thr(1), rv); chk("R3 threshold readback", rv, 5);
        wr(a_thr(1), 0);

        // Strict threshold
        wr(a_prio(3), 2); wr(a_en(0), 32'h8); wr(a_thr(0), 2);
        irq_src[3] = 1'b1; tick(2);
        chk("R4 equal to threshold", 32'(ctx_irq), 0);
        wr(a_thr(0), 1); tick(1);
        chk("R4 above threshold", 32'(ctx_irq), 1);
        wr(a_prio(3), 7); wr(a_thr(0), 7); tick(1);
        chk("R4 threshold 7 masks", 32'(ctx_irq), 0);
        wr(a_prio(3), 2); wr(a_thr(0), 0); tick(1);

        // Claim blocks re-arming; completion rules
        rd(a_clm(0), rv); chk("R5 claim level", rv, 3);
        tick(1); chk("R7 irq drops when busy", 32'(ctx_irq), 0);
        rd(a_clm(0), rv); chk("R7 no re-arm while busy", rv, 0);
        wr(a_clm(0), 2); wr(a_clm(0), 40); wr(a_clm(1), 3); wr(a_clm(0), 0);
        tick(1); rd(a_clm(0), rv); chk("R8 bad completions ignored", rv, 0);
        wr(a_clm(0), 3); tick(1);
        rd(a_clm(0), rv); chk("R7 level re-pends after completion", rv, 3);
        irq_src[3] = 1'b0; wr(a_clm(0), 3); tick(2);
        rd(a_clm(0), rv); chk("R7 low level stays idle", rv, 0);

        // Priority order and ties
        wr(a_prio(4), 5); wr(a_prio(10), 5); wr(a_prio(12), 4);
        wr(a_en(0), (32'h1 << 4) | (32'h1 << 10) | (32'h1 << 12));
        irq_src[4] = 1'b1; irq_src[10] = 1'b1; irq_src[12] = 1'b1; tick(2);
        rd(a_clm(0), rv); chk("R5 tie lowest id", rv, 4);
        rd(a_clm(0), rv); chk("R5 second of tie", rv, 10);
        rd(a_clm(0), rv); chk("R5 lower priority last", rv, 12);
        rd(a_clm(0), rv); chk("R5 none left", rv, 0);
        irq_src = '0;
        wr(a_clm(0), 4); wr(a_clm(0), 10); wr(a_clm(0), 12); tick(2);

        // Atomic claim across contexts
        wr(a_en(1), 32'h1 << 4);
        irq_src[4] = 1'b1; tick(2);
        chk("R4 both contexts raised", 32'(ctx_irq), 3);
        rd(a_clm(0), rv); chk("R6 first context wins", rv, 4);
        rd(a_clm(1), rv); chk("R6 second context gets 0", rv, 0);
        irq_src[4] = 1'b0; wr(a_clm(1), 4); tick(2);
        rd(a_clm(0), rv); chk("R6 completion from other context", rv, 0);

        // Edge mode (source 5 is edge: bit 5 of EDGE_SEL)
        wr(a_prio(5), 6); wr(a_en(0), 32'h1 << 5);
        irq_src[5] = 1'b1; tick(1); irq_src[5] = 1'b0; tick(1);
        chk("R9 edge raises irq", 32'(ctx_irq), 1);
        rd(a_clm(0), rv); chk("R9 edge claim", rv, 5);
        irq_src[5] = 1'b1; tick(1); irq_src[5] = 1'b0; tick(1);
        wr(a_clm(0), 5); tick(2);
        rd(a_clm(0), rv); chk("R9 edge while busy dropped", rv, 0);
        irq_src[5] = 1'b1; tick(2);
        rd(a_clm(0), rv); chk("R9 new edge pends", rv, 5);
        wr(a_clm(0), 5); tick(2);
        rd(a_clm(0), rv); chk("R9 held high no re-pend", rv, 0);
        irq_src[5] = 1'b0;

        // Random configurations against the model
        for (int it = 0; it < 30; it++) begin
            logic [31:0] lvl;
            int c;
            int e;
            do_reset();
            for (int i = 1; i <= NSRC; i++) begin
                prio_m[i] = $urandom_range(0, 7);
                wr(a_prio(i), 32'(prio_m[i]));
            end
            for (int k = 0; k < NCTX; k++) begin
                en_m[k]  = $urandom & 32'hFFFF_FFFE;
                thr_m[k] = $urandom_range(0, 4);
                wr(a_en(k), en_m[k]);
                wr(a_thr(k), 32'(thr_m[k]));
            end
            lvl = $urandom & LVL_MASK;
            irq_src = lvl[31:1];
            tick(2);
            for (int k = 0; k < NCTX; k++)
                chk("R4 random irq", 32'(ctx_irq[k]), 32'(exp_win(k, lvl) != 0));
            c = $urandom_range(0, NCTX - 1);
            e = exp_win(c, lvl);
            rd(a_clm(c), rv); chk("R5 random claim", rv, 32'(e));
            irq_src = '0;
        end

        summary();
        $finish;
    end
endmodule